// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupt

This block keeps a free-running cycle counter and a compare register of the same width. Both sit behind a small register port in the style of a system coprocessor: one address selects the counter, another the compare value, and a write on either loads it. The counter moves forward by one on every clock edge. Stalls, cache misses and host traffic have no way to pause it. A software write replaces the increment for that cycle, and the count carries on from the written value.

When the counter takes a new value equal to the compare value, a sticky timer-pending flag sets. Only a write to the compare register clears it. The interrupt request is the pending flag gated by the timer bit of an interrupt mask byte and by the current global interrupt enable. A separate read-only output mirrors the counter for a second register space, such as the control registers of a vector unit.

Top module: `cycle_timer`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, the counter, the compare register and the pending flag are cleared to 0, and `irq_o` is 0.
- R2: With no counter write, the counter increases by exactly one on every clock edge.
- R3: A write to address 0 loads the counter with the write data at that edge, in place of the increment. Counting then continues from the loaded value.
- R4: A write to address 1 loads the compare register. Address 1 reads the compare register back, address 0 reads the counter, and addresses 2 and 3 read as 0.
- R5: The counter wraps from 0xFFFFFFFF to 0 with no other effect. The pending flag stays clear unless the compare value is 0.
- R6: The pending flag is 1 from the first cycle in which the counter output takes a new value equal to the compare value. This holds whether the counter got there by incrementing or by a write.
- R7: Once set, the pending flag stays set through further counting and through counter writes. A compare write clears it at that edge, and the clear wins over a match at the same edge.
- R8: `irq_o` equals pending AND `int_mask_i[7]` AND `gie_i`, combinationally. Mask bits 0 to 6 have no effect.
- R9: `shadow_count_o` equals the counter value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr_i | input | 2 | Register select: 0 counter, 1 compare |
| acc_wr_i | input | 1 | Write strobe for the selected register |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data of the selected register |
| int_mask_i | input | 8 | Interrupt mask byte; bit 7 enables the timer |
| gie_i | input | 1 | Current global interrupt enable |
| pending_o | output | 1 | Sticky timer-pending flag |
| irq_o | output | 1 | Gated timer interrupt request |
| shadow_count_o | output | 32 | Read-only mirror of the counter |

## Verification
The hardest state to reach from the ports is equality between a 32-bit counter and the compare value. Waiting for it would take billions of cycles. The bench therefore loads the counter a chosen distance below the compare value and sweeps that distance, so the flag must rise on exactly the expected edge. The bench also writes the compare register on the very edge the counter reaches it, to show that the clear wins. It loads the counter just below the top of its range to force the wrap.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the cycle timer: register-port address width and select codes.
package tmr_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMP   = 2'd1
    } tmr_sel_e;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Free-running counter. It increments every cycle, or loads a software value
// in place of the increment. It also exposes its next value so that a
// comparator can look at the value being entered.
// Assumes: synchronous active-low reset; wrap is plain modulo 2^CNT_W.
module tmr_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nxt_o
);
    logic [CNT_W-1:0] count_q;

    // Next value: a software load replaces the increment
    always_comb begin
        count_nxt_o = load_i ? load_val_i : count_q + CNT_W'(1);
    end

    // Counter register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_nxt_o;
    end

    assign count_o = count_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> count_q == $past(count_q) + CNT_W'(1)); // R2
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_q == $past(load_val_i)); // R3
endmodule

// File: rtl/tmr_match.sv
`timescale 1ns/1ps
// Compare register and sticky pending flag. The flag sets when the counter's
// next value equals the held compare value. Only a compare write clears it,
// and that clear has priority over a match at the same edge.
// Assumes: synchronous active-low reset; count_nxt_i is the value the counter enters.
module tmr_match #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wval_i,
    input  logic [CNT_W-1:0] count_nxt_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pend_o
);
    logic [CNT_W-1:0] cmp_q;
    logic             pend_q;
    logic             hit;

    // Equality on the value being entered, against the compare value in force
    always_comb begin
        hit = (count_nxt_i == cmp_q);
    end

    // Compare register: loaded only by a software write
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (cmp_wr_i) cmp_q <= cmp_wval_i;
    end

    // Pending flag: clear on compare write, else set on hit, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (cmp_wr_i) pend_q <= 1'b0;
        else if (hit)      pend_q <= 1'b1;
    end

    assign cmp_o  = cmp_q;
    assign pend_o = pend_q;

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> !pend_q); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cmp_wr_i) |=> pend_q); // R7
endmodule

// File: rtl/tmr_irq_gate.sv
`timescale 1ns/1ps
// Interrupt gating: passes the pending flag when the timer mask bit and the
// global enable are both set. It is purely combinational, with no added latency.
// Assumes: MASK_IDX lies inside the mask byte.
module tmr_irq_gate #(
    parameter int unsigned MASK_W   = 8,
    parameter int unsigned MASK_IDX = 7
) (
    input  logic              pend_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              gie_i,
    output logic              irq_o
);
    // Three-input gate on the timer mask bit and the global enable
    always_comb begin
        irq_o = pend_i & mask_i[MASK_IDX] & gie_i;
    end
endmodule

// File: rtl/cycle_timer.sv
`timescale 1ns/1ps
// Top of the cycle timer: counter, compare/pending logic, interrupt gate,
// register read mux and a read-only shadow of the count.
// Assumes: single clock, synchronous active-low reset, one register access per cycle.
module cycle_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned MASK_W   = 8,
    parameter int unsigned MASK_IDX = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] acc_addr_i,
    input  logic                  acc_wr_i,
    input  logic [CNT_W-1:0]      acc_wdata_i,
    output logic [CNT_W-1:0]      acc_rdata_o,
    input  logic [MASK_W-1:0]     int_mask_i,
    input  logic                  gie_i,
    output logic                  pending_o,
    output logic                  irq_o,
    output logic [CNT_W-1:0]      shadow_count_o
);
    logic             wr_count;
    logic             wr_cmp;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] cmp;
    logic             pend;

    // Address decode of the write strobe
    always_comb begin
        wr_count = acc_wr_i && (acc_addr_i == SEL_COUNT);
        wr_cmp   = acc_wr_i && (acc_addr_i == SEL_CMP);
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (wr_count),
        .load_val_i  (acc_wdata_i),
        .count_o     (count),
        .count_nxt_o (count_nxt)
    );

    tmr_match #(.CNT_W(CNT_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_wr_i    (wr_cmp),
        .cmp_wval_i  (acc_wdata_i),
        .count_nxt_i (count_nxt),
        .cmp_o       (cmp),
        .pend_o      (pend)
    );

    tmr_irq_gate #(.MASK_W(MASK_W), .MASK_IDX(MASK_IDX)) u_gate (
        .pend_i (pend),
        .mask_i (int_mask_i),
        .gie_i  (gie_i),
        .irq_o  (irq_o)
    );

    // Read mux: counter, compare, else zero
    always_comb begin
        case (acc_addr_i)
            SEL_COUNT: acc_rdata_o = count;
            SEL_CMP:   acc_rdata_o = cmp;
            default:   acc_rdata_o = '0;
        endcase
    end

    assign pending_o      = pend;
    assign shadow_count_o = count;

    AST_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> count == cmp); // R6
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && gie_i)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && cmp == '0 && !pend)); // R1
endmodule

// File: tb/cycle_timer_test.sv
`timescale 1ns/1ps
module cycle_timer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  acc_addr;
    logic        acc_wr;
    logic [31:0] acc_wdata;
    logic [31:0] acc_rdata;
    logic [7:0]  int_mask;
    logic        gie;
    logic        pending;
    logic        irq;
    logic [31:0] shadow;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    cycle_timer uut (
        .clk(clk), .rst_n(rst_n), .acc_addr_i(acc_addr), .acc_wr_i(acc_wr),
        .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata), .int_mask_i(int_mask),
        .gie_i(gie), .pending_o(pending), .irq_o(irq), .shadow_count_o(shadow)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        acc_addr = a; acc_wr = 1'b1; acc_wdata = d;
        tick();
        acc_wr = 1'b0; acc_addr = 2'd0;
        #0.5;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        acc_addr = a;
        #0.5;
        d = acc_rdata;
        acc_addr = 2'd0;
        #0.5;
    endtask

    task automatic chk_count(input string tag, input logic [31:0] exp);
        chk({tag, " count"}, acc_rdata, exp);
        chk({"R9 shadow"}, shadow, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c;
        rst_n = 1'b0; acc_addr = 2'd0; acc_wr = 1'b0; acc_wdata = '0;
        int_mask = 8'h80; gie = 1'b1;
        tick(); tick();
        // R1 reset state
        chk_count("R1", 32'd0);
        rd(2'd1, v); chk("R1 compare", v, 32'd0);
        chk("R1 pending", {31'd0, pending}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 increment per cycle
        rst_n = 1'b1;
        tick();
        for (int i = 1; i <= 20; i++) begin
            chk_count("R2", 32'(i));
            tick();
        end

        // R3 counter load replaces increment
        wr(2'd0, 32'h1234_5678);
        chk_count("R3 load", 32'h1234_5678);
        tick();
        chk_count("R3 continue", 32'h1234_5679);

        // R4 compare read back and unused addresses
        wr(2'd1, 32'hA5A5_0000);
        rd(2'd1, v); chk("R4 compare", v, 32'hA5A5_0000);
        rd(2'd2, v); chk("R4 addr2", v, 32'd0);
        rd(2'd3, v); chk("R4 addr3", v, 32'd0);
        chk("R4 pending", {31'd0, pending}, 32'd0);

        // R6 sweep of distance below compare
        c = 32'h0000_8000;
        for (int d = 1; d <= 12; d++) begin
            wr(2'd1, c);
            chk("R7 clear", {31'd0, pending}, 32'd0);
            wr(2'd0, c - 32'(d));
            chk("R6 before", {31'd0, pending}, 32'd0);
            for (int k = 1; k <= d; k++) begin
                tick();
                chk("R6 pending", {31'd0, pending}, {31'd0, k == d});
                chk("R8 irq", {31'd0, irq}, {31'd0, k == d});
            end
            chk_count("R6 at match", c);
        end

        // R7 sticky through counting and counter writes
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R7 sticky", {31'd0, pending}, 32'd1);
        end
        wr(2'd0, 32'h10);
        chk("R7 count write keeps", {31'd0, pending}, 32'd1);

        // R8 gate sweep with pending set and clear
        for (int p = 0; p < 2; p++) begin
            if (p == 1) begin
                wr(2'd1, c);
                chk("R7 clear", {31'd0, pending}, 32'd0);
            end
            for (int g = 0; g < 2; g++) begin
                for (int m = 0; m < 256; m++) begin
                    int_mask = 8'(m); gie = g[0];
                    #0.1;
                    chk("R8 gate", {31'd0, irq}, {31'd0, (p == 0) && m[7] && (g == 1)});
                end
            end
        end
        int_mask = 8'h80; gie = 1'b1;

        // R7 clear wins over a same-edge match
        wr(2'd1, 32'h40);
        wr(2'd0, 32'h3F);
        wr(2'd1, 32'h40);
        chk("R7 clear wins", {31'd0, pending}, 32'd0);
        chk_count("R7 collide", 32'h40);
        tick();
        chk("R7 no late set", {31'd0, pending}, 32'd0);

        // R5 wrap with nonzero compare
        wr(2'd1, 32'h100);
        wr(2'd0, 32'hFFFF_FFFE);
        tick();
        chk_count("R5 top", 32'hFFFF_FFFF);
        tick();
        chk_count("R5 wrap", 32'd0);
        chk("R5 no pending", {31'd0, pending}, 32'd0);
        tick();
        chk_count("R5 after", 32'd1);

        // R6 wrap onto compare of zero
        wr(2'd1, 32'd0);
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R6 pre-wrap", {31'd0, pending}, 32'd0);
        tick();
        chk("R6 wrap match", {31'd0, pending}, 32'd1);

        // R6 match reached by a counter write
        wr(2'd1, 32'h77);
        wr(2'd0, 32'h77);
        chk("R6 write match", {31'd0, pending}, 32'd1);

        // R1 reset during operation
        rst_n = 1'b0;
        tick();
        chk_count("R1 mid", 32'd0);
        rd(2'd1, v); chk("R1 mid compare", v, 32'd0);
        chk("R1 mid pending", {31'd0, pending}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule